// File: doc/BRIEF.md
# Multiplexed SAR Converter Serial Port

This block is a synthesizable digital stand-in for the control and serial side of an eight-input, 12-bit successive-approximation converter. It can serve as a device under test or as a bus-functional partner for a host controller. A rising edge on the conversion strobe captures the sample value supplied on `sample_in` and starts a busy period of programmable length. When that period ends, the formatted result is latched into an output register. Depending on the level of the strobe at that moment, the block either becomes ready at once or drops into one of two low-power states.

The serial transfer is full duplex. While the strobe is low and no conversion runs, the result of the previous conversion leaves on `sdo`, most significant bit first. At the same time, a six-bit configuration word enters on `sdi`. This word chooses the input routing, the output code format (straight binary or two's complement) and which low-power state follows the next conversion. Serial clock edges are detected in the system clock domain, so `sclk` must stay at each level for at least two `clk` periods.

Top module: `adc_serial_port`

## Requirements
- R1: After reset the power state is READY (code 0), `sdo_oe` is 1, `sdo` is 0, and `cfg_word` is 6'b000010 (unipolar, nap).
- R2: A rising edge of `conv_start` in READY sets the power state to CONVERT (code 1) for exactly CONV_CYCLES clock cycles, counted from the edge at which the rise is first seen.
- R3: A rising edge of `conv_start` during CONVERT or WAKE (code 4) neither restarts nor lengthens the busy or wake period.
- R4: `sdo_oe` is 1 only when the power state is READY and `conv_start` is low. Otherwise it is 0 and `sdo` is 0.
- R5: If `conv_start` is low when a conversion ends, the state returns to READY in that same cycle and `sdo` shows result bit 11 at once.
- R6: `sdo` presents result bits 11 down to 0. It advances by one bit after each `sclk` falling edge seen during the data phase.
- R7: After the twelfth falling edge, `sdo` stays 0 while the data phase lasts, including under further falling edges.
- R8: `sdi` is sampled on the first six `sclk` rising edges of a data phase. The first bit lands in `cfg_word[5]` (single-ended select), then [4] (odd/sign), [3:2] (pair select), [1] (1 = unipolar) and [0] (1 = sleep). `cfg_word` changes only on the sixth rising edge. Later rising edges are ignored.
- R9: A data phase with fewer than six rising edges leaves `cfg_word` unchanged.
- R10: The shifted-out word is the result of the most recent conversion. The sample is captured when the conversion starts, using the unipolar bit that is active at that moment. Unipolar gives the sample unchanged. Bipolar gives the sample minus 2048, modulo 4096.
- R11: If `conv_start` is high when a conversion ends, the state becomes NAP (code 2) when `cfg_word[0]` is 0 and SLEEP (code 3) when it is 1.
- R12: In NAP, a low `conv_start` returns the state to READY at the next clock edge.
- R13: In SLEEP, a low `conv_start` moves the state to WAKE. The state stays in WAKE for WAKE_CYCLES cycles and then becomes READY.
- R14: `sclk` edges outside the data phase (during a conversion) change neither `cfg_word` nor the position in the output word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_start | input | 1 | Conversion strobe; rising edge starts a conversion, level gates output and low-power entry |
| sclk | input | 1 | Serial clock, oversampled by `clk` |
| sdi | input | 1 | Serial configuration input, sampled on `sclk` rising edges |
| sample_in | input | DATA_W | Raw sample code presented by the environment |
| sdo | output | 1 | Serial result output (0 when not enabled) |
| sdo_oe | output | 1 | Output enable for `sdo`; 0 means high impedance |
| pwr_state | output | 3 | 0 READY, 1 CONVERT, 2 NAP, 3 SLEEP, 4 WAKE |
| cfg_word | output | 6 | Active configuration word |

## Verification
The end of a conversion and the level of the strobe meet in one cycle. That single cycle decides between ready, nap and sleep, and it also loads the result register that the first output bit reads. The bench lets conversions end with the strobe held high in some runs and low in others, under both sleep-bit settings. In the same cycle it checks the state code, the enable and the most significant bit against a result it formats itself. Strobe re-raises and serial clock pulses that land inside the busy or wake window are also provoked, and are judged by an unchanged window length, configuration and bit position.

// File: rtl/adc_port_pkg.sv
package adc_port_pkg;

  localparam int CFG_W = 6;

  typedef enum logic [2:0] {
    PS_READY   = 3'd0,
    PS_CONVERT = 3'd1,
    PS_NAP     = 3'd2,
    PS_SLEEP   = 3'd3,
    PS_WAKE    = 3'd4
  } pwr_state_e;

  // first serial bit lands in the top field
  typedef struct packed {
    logic       single_end;
    logic       odd_sign;
    logic [1:0] pair_sel;
    logic       unipolar;
    logic       deep_sleep;
  } cfg_t;

  localparam cfg_t CFG_RESET = cfg_t'(6'b000010);

endpackage

// File: rtl/adc_edge_det.sv
module adc_edge_det #(
  parameter logic RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic rise,
  output logic fall
);

  logic level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= RESET_VAL;
    else        level_q <= level;
  end

  assign rise = level & ~level_q;
  assign fall = ~level & level_q;

endmodule

// File: rtl/adc_pwr_seq.sv
module adc_pwr_seq
  import adc_port_pkg::*;
#(
  parameter int CONV_CYCLES = 260,
  parameter int WAKE_CYCLES = 40_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       conv_start,
  input  logic       cs_rise,
  input  logic       cfg_sleep,
  output pwr_state_e state,
  output logic       conv_launch,
  output logic       conv_done
);

  localparam int CNT_W = $clog2(CONV_CYCLES + 1);
  localparam int WK_W  = $clog2(WAKE_CYCLES + 1);

  logic [CNT_W-1:0] conv_cnt;
  logic [WK_W-1:0]  wake_cnt;
  logic             wake_done;

  assign conv_launch = (state == PS_READY) && cs_rise;
  assign conv_done   = (state == PS_CONVERT) && (conv_cnt == '0);
  assign wake_done   = (state == PS_WAKE) && (wake_cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= PS_READY;
      conv_cnt <= '0;
      wake_cnt <= '0;
    end else begin
      case (state)
        PS_READY: begin
          if (cs_rise) begin
            state    <= PS_CONVERT;
            conv_cnt <= CNT_W'(CONV_CYCLES - 1);
          end
        end
        PS_CONVERT: begin
          if (conv_done) begin
            if (!conv_start)    state <= PS_READY;
            else if (cfg_sleep) state <= PS_SLEEP;
            else                state <= PS_NAP;
          end else begin
            conv_cnt <= conv_cnt - 1'b1;
          end
        end
        PS_NAP: begin
          if (!conv_start) state <= PS_READY;
        end
        PS_SLEEP: begin
          if (!conv_start) begin
            state    <= PS_WAKE;
            wake_cnt <= WK_W'(WAKE_CYCLES - 1);
          end
        end
        PS_WAKE: begin
          if (wake_done) state <= PS_READY;
          else           wake_cnt <= wake_cnt - 1'b1;
        end
        default: state <= PS_READY;
      endcase
    end
  end

  // busy window counts straight down whatever the strobe does (R3)
  assert_busy_no_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PS_CONVERT && !conv_done) |=>
      (state == PS_CONVERT && conv_cnt == $past(conv_cnt) - 1'b1));

  assert_end_lowpower_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && conv_start) |=> (state == PS_NAP || state == PS_SLEEP));

  assert_sleep_to_wake_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PS_SLEEP && !conv_start) |=> (state == PS_WAKE));

  assert_wake_count_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PS_WAKE && !wake_done) |=>
      (state == PS_WAKE && wake_cnt == $past(wake_cnt) - 1'b1));

endmodule

// File: rtl/adc_cfg_capture.sv
module adc_cfg_capture
  import adc_port_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic frame_clr,
  input  logic data_phase,
  input  logic sck_rise,
  input  logic sdi,
  output cfg_t cfg
);

  logic [2:0]       rise_cnt;
  logic [CFG_W-2:0] shreg;
  logic             take;
  logic             cfg_load;

  assign take     = data_phase && sck_rise && (rise_cnt < 3'(CFG_W));
  assign cfg_load = take && (rise_cnt == 3'(CFG_W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_cnt <= '0;
      shreg    <= '0;
      cfg      <= CFG_RESET;
    end else if (frame_clr) begin
      rise_cnt <= '0;
    end else if (take) begin
      shreg    <= {shreg[CFG_W-3:0], sdi};
      rise_cnt <= rise_cnt + 1'b1;
      if (cfg_load) cfg <= cfg_t'({shreg, sdi});
    end
  end

  assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_load |=> $stable(cfg));

  assert_rise_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !frame_clr) |=> (rise_cnt == $past(rise_cnt) + 1'b1));

endmodule

// File: rtl/adc_result_out.sv
module adc_result_out #(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic              done,
  input  logic              frame_clr,
  input  logic              data_phase,
  input  logic              sck_fall,
  input  logic              uni_now,
  input  logic [DATA_W-1:0] sample_in,
  output logic              sdo_bit
);

  localparam int FW = $clog2(DATA_W + 1);

  logic [DATA_W-1:0] hold;
  logic              uni_hold;
  logic [DATA_W-1:0] result;
  logic [FW-1:0]     fall_cnt;
  logic [FW-1:0]     bit_sel;
  logic              tail;

  // offset-binary sample to output code
  function automatic logic [DATA_W-1:0] fmt_code(input logic [DATA_W-1:0] raw,
                                                 input logic uni);
    fmt_code = uni ? raw : {~raw[DATA_W-1], raw[DATA_W-2:0]};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold     <= '0;
      uni_hold <= 1'b1;
      result   <= '0;
    end else begin
      if (launch) begin
        hold     <= sample_in;
        uni_hold <= uni_now;
      end
      if (done) result <= fmt_code(hold, uni_hold);
    end
  end

  assign tail = (fall_cnt >= FW'(DATA_W));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             fall_cnt <= '0;
    else if (frame_clr)                     fall_cnt <= '0;
    else if (data_phase && sck_fall && !tail) fall_cnt <= fall_cnt + 1'b1;
  end

  assign bit_sel = FW'(DATA_W - 1) - fall_cnt;
  assign sdo_bit = tail ? 1'b0 : result[bit_sel];

  assert_bit_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_cnt != $past(fall_cnt)) |->
      (fall_cnt == $past(fall_cnt) + 1'b1 || fall_cnt == '0));

  assert_result_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(result));

endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port
  import adc_port_pkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int CONV_CYCLES = 260,
  parameter int WAKE_CYCLES = 40_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_start,
  input  logic              sclk,
  input  logic              sdi,
  input  logic [DATA_W-1:0] sample_in,
  output logic              sdo,
  output logic              sdo_oe,
  output logic [2:0]        pwr_state,
  output logic [CFG_W-1:0]  cfg_word
);

  logic       cs_rise, cs_fall;
  logic       sck_rise, sck_fall;
  pwr_state_e st;
  logic       conv_launch, conv_done;
  logic       frame_clr, data_phase;
  logic       sdo_bit;
  cfg_t       cfg;

  adc_edge_det #(.RESET_VAL(1'b0)) u_cs_edge (
    .clk(clk), .rst_n(rst_n), .level(conv_start), .rise(cs_rise), .fall(cs_fall)
  );

  adc_edge_det #(.RESET_VAL(1'b0)) u_sck_edge (
    .clk(clk), .rst_n(rst_n), .level(sclk), .rise(sck_rise), .fall(sck_fall)
  );

  adc_pwr_seq #(.CONV_CYCLES(CONV_CYCLES), .WAKE_CYCLES(WAKE_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .cs_rise(cs_rise),
    .cfg_sleep(cfg.deep_sleep), .state(st),
    .conv_launch(conv_launch), .conv_done(conv_done)
  );

  assign frame_clr  = conv_launch | conv_done;
  assign data_phase = (st == PS_READY) && !conv_start;

  adc_cfg_capture u_cfg (
    .clk(clk), .rst_n(rst_n), .frame_clr(frame_clr), .data_phase(data_phase),
    .sck_rise(sck_rise), .sdi(sdi), .cfg(cfg)
  );

  adc_result_out #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst_n(rst_n), .launch(conv_launch), .done(conv_done),
    .frame_clr(frame_clr), .data_phase(data_phase), .sck_fall(sck_fall),
    .uni_now(cfg.unipolar), .sample_in(sample_in), .sdo_bit(sdo_bit)
  );

  assign sdo_oe    = data_phase;
  assign sdo       = data_phase & sdo_bit;
  assign pwr_state = st;
  assign cfg_word  = cfg;

  assert_nap_release_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PS_NAP && cs_fall) |=> (pwr_state == 3'd0));

  assert_sck_ignored_R14: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PS_CONVERT) |=> $stable(cfg_word));

  assert_quiet_when_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state != 3'd0) |-> (!sdo_oe && !sdo));

endmodule

// File: tb/adc_serial_port_test.sv
`timescale 1ns/1ps
module adc_serial_port_test;

  localparam int DW   = 12;
  localparam int CONV = 8;
  localparam int WAKE = 40;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          conv_start = 1'b0;
  logic          sclk = 1'b0;
  logic          sdi = 1'b0;
  logic [DW-1:0] sample_in = '0;
  logic          sdo, sdo_oe;
  logic [2:0]    pwr_state;
  logic [5:0]    cfg_word;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  logic [5:0]  m_cfg = 6'b000010;
  logic [11:0] m_res = 12'h000;

  always #2.5 clk = ~clk;

  adc_serial_port #(.DATA_W(DW), .CONV_CYCLES(CONV), .WAKE_CYCLES(WAKE)) uut (
    .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .sclk(sclk), .sdi(sdi),
    .sample_in(sample_in), .sdo(sdo), .sdo_oe(sdo_oe),
    .pwr_state(pwr_state), .cfg_word(cfg_word)
  );

  function automatic logic [11:0] bench_code(input logic [11:0] s, input logic uni);
    if (uni) return s;
    return s - 12'd2048;
  endfunction

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic sck_pulse(input logic d);
    sdi  = d;
    sclk = 1'b1;
    step(2);
    sclk = 1'b0;
    step(2);
  endtask

  task automatic read_frame(input logic [5:0] din, input int n);
    for (int i = 0; i < n; i++) begin
      if (i < 12) chk("R6/R10 bit", sdo, m_res[11-i]);
      sck_pulse((i < 6) ? din[5-i] : 1'($urandom));
    end
    if (n >= 12) begin
      chk("R7 tail", sdo, 0);
      chk("R7 oe", sdo_oe, 1);
    end
    if (n >= 6) begin
      m_cfg = din;
      chk("R8 cfg", cfg_word, m_cfg);
    end else begin
      chk("R9 cfg", cfg_word, m_cfg);
    end
  endtask

  task automatic run_conv(input logic [11:0] s, input bit keep_high,
                          input bit glitch, input bit noise);
    logic conv_uni;
    logic slp;
    int   used;
    conv_uni   = m_cfg[1];
    slp        = m_cfg[0];
    sample_in  = s;
    conv_start = 1'b1;
    step(1);
    used = 1;
    chk("R2 start", pwr_state, 1);
    chk("R4 oe busy", sdo_oe, 0);
    if (glitch) begin
      conv_start = 1'b0;
      step(1);
      conv_start = 1'b1;
      step(1);
      used += 2;
    end
    conv_start = keep_high;
    if (noise) begin
      sck_pulse(1'b1);
      used += 4;
    end
    step(CONV - used);
    chk(glitch ? "R3 busy" : "R2 busy", pwr_state, 1);
    sample_in = ~s;
    step(1);
    m_res = bench_code(s, conv_uni);
    if (!keep_high) begin
      chk("R5 state", pwr_state, 0);
      chk("R5 oe", sdo_oe, 1);
      chk("R5 msb", sdo, m_res[11]);
    end else begin
      chk("R11 state", pwr_state, slp ? 3 : 2);
      chk("R4 oe high", sdo_oe, 0);
      conv_start = 1'b0;
      if (slp) begin
        step(1);
        chk("R13 wake", pwr_state, 4);
        conv_start = 1'b1;
        step(1);
        chk("R3 wake", pwr_state, 4);
        conv_start = 1'b0;
        step(WAKE - 2);
        chk("R13 still waking", pwr_state, 4);
        chk("R4 oe wake", sdo_oe, 0);
        step(1);
        chk("R13 ready", pwr_state, 0);
      end else begin
        step(1);
        chk("R12 ready", pwr_state, 0);
      end
      chk("R12 oe", sdo_oe, 1);
      chk("R12 msb", sdo, m_res[11]);
    end
    if (noise) chk("R14 cfg", cfg_word, m_cfg);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog act=hung exp=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_2024));
    step(3);
    rst_n = 1'b1;
    step(1);
    chk("R1 state", pwr_state, 0);
    chk("R1 oe", sdo_oe, 1);
    chk("R1 sdo", sdo, 0);
    chk("R1 cfg", cfg_word, 6'b000010);

    // directed corners
    run_conv(12'hA5C, 1'b0, 1'b0, 1'b0);
    read_frame(6'b100010, 12);
    run_conv(12'h3C1, 1'b0, 1'b1, 1'b1);
    read_frame(6'b011100, 14);
    run_conv(12'h800, 1'b1, 1'b0, 1'b0);   // bipolar midscale, nap
    read_frame(6'b000011, 3);              // partial: no change
    run_conv(12'h7FF, 1'b0, 1'b0, 1'b0);
    read_frame(6'b000011, 12);
    run_conv(12'h123, 1'b1, 1'b0, 1'b0);   // sleep path
    read_frame(6'b110001, 12);
    run_conv(12'h000, 1'b1, 1'b1, 1'b1);   // sleep, bipolar, glitches
    read_frame(6'b000010, 12);

    // constrained random
    for (int k = 0; k < 20; k++) begin
      logic [11:0] s;
      logic [5:0]  d;
      s = 12'($urandom);
      d = 6'($urandom);
      run_conv(s, 1'($urandom), 1'($urandom), 1'($urandom));
      read_frame(d, int'($urandom_range(14, 2)));
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule